// File: doc/BRIEF.md
# DMA Synchronisation and Threshold Planner

This block works out how a DMA engine should pace transfers for one stream of an audio serial port. A stream is described by its period length in bytes, its sample width (16 or 32 bits), its channel count, the largest FIFO threshold that its direction allows, and a flag that selects threshold pacing. From these the block produces three things. It picks a sync mode: per element, per frame or per packet. It gives a packet size. It gives the FIFO threshold in words.

Most requests are settled in one clock. The one exception is a threshold-paced stream whose period holds more words than the allowed threshold. For that case the period must be cut into equal packets that each fit under the threshold. The block searches for the smallest divisor of the period, starting from the ceiling of period over maximum. It tries one candidate per clock and uses a single modulo test each time. If the only divisor it finds is the period itself, the request is refused with an error.

A requester pulses `start` with the inputs valid. The result stays on the outputs until the next `done`.

Top module: `dma_thresh_planner`

## Requirements
- R1: The period word count is `period_bytes` shifted right by 1 when `wide_sample`=0 (16-bit samples) and by 2 when `wide_sample`=1 (32-bit samples); any leftover bytes are dropped.
- R2: With `thresh_mode`=1 and a word count P no larger than the maximum M, the result is frame sync (`sync_mode`=1), `pkt_size`=0, `thresh_words`=P and `err`=0.
- R3: With `thresh_mode`=1 and P>M, a candidate divider starts at ceil(P/M) and grows by one per clock until it divides P evenly or equals P.
- R4: When the divider that stops the search equals P, `err`=1 and `sync_mode`, `pkt_size` and `thresh_words` are all 0.
- R5: When the search succeeds, `sync_mode`=2 (packet), `pkt_size`=P/divider, and `thresh_words` equals `pkt_size`. This makes `pkt_size` the largest divisor of P that is no more than M.
- R6: With `thresh_mode`=0 and `channels`>1, the result is packet sync (2) with `pkt_size` and `thresh_words` equal to the channel count.
- R7: With `thresh_mode`=0 and `channels` of 0 or 1, the result is element sync (0), `pkt_size`=0 and `thresh_words`=1.
- R8: A `max_thresh` of 0 is treated as 1.
- R9: `done` is a one-clock pulse. For every case that needs no search it rises on the first clock edge after `start` is sampled. The outputs hold their values until the next `done`.
- R10: A `start` that arrives while a search runs is ignored. The inputs in that cycle neither change the result nor cause an extra `done`.
- R11: `done` rises no later than P clock edges after the edge that sampled `start`, so within 4095 edges for 12-bit word counts.
- R12: After reset, `done`, `err`, `sync_mode`, `pkt_size` and `thresh_words` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; inputs are sampled with it |
| period_bytes | input | WORD_W+1 | Period length in bytes |
| wide_sample | input | 1 | 0: 16-bit samples, 1: 32-bit samples |
| max_thresh | input | WORD_W | Largest FIFO threshold for the stream direction |
| channels | input | CH_W | Channel count |
| thresh_mode | input | 1 | 1 selects threshold pacing |
| done | output | 1 | One-clock result strobe |
| err | output | 1 | No valid packet split exists |
| sync_mode | output | 2 | 0 element, 1 frame, 2 packet |
| pkt_size | output | WORD_W | Packet size in words (0 when unused) |
| thresh_words | output | WORD_W | FIFO threshold in words |

## Verification
Two events can fall in the same cycle: a new request arriving, and a running divisor search reaching its end. The bench provokes this by holding `start` high, with a different request on the inputs, for the whole of a search, including the clock edge where the search finishes. It then releases `start` before the edge that follows. The result is judged correct if exactly one `done` appears, it carries the first request's packet split, and no further `done` follows in the next cycles.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  typedef enum logic [1:0] {
    SYNC_ELEMENT = 2'd0,
    SYNC_FRAME   = 2'd1,
    SYNC_PACKET  = 2'd2
  } sync_e;
endpackage

// File: rtl/dtp_word_conv.sv
module dtp_word_conv #(
  parameter int WORD_W = 12
) (
  input  logic [WORD_W:0]   bytes_in,
  input  logic              wide,
  output logic [WORD_W-1:0] words_out
);
  logic [WORD_W:0] shifted;
  logic            unused_msb;

  // 16-bit samples: two bytes per word; 32-bit samples: four bytes per word (R1)
  assign shifted    = wide ? (bytes_in >> 2) : (bytes_in >> 1);
  assign words_out  = shifted[WORD_W-1:0];
  assign unused_msb = shifted[WORD_W];
endmodule

// File: rtl/dtp_div_search.sv
module dtp_div_search #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] per_in,
  input  logic [WORD_W-1:0] div_in,
  output logic              busy,
  output logic              finish,
  output logic              fail,
  output logic [WORD_W-1:0] quot
);
  logic [WORD_W-1:0] per_q, div_q;
  logic [WORD_W:0]   step_cnt;
  logic              busy_q, advance;

  function automatic logic has_rem(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    return (b == '0) ? 1'b0 : ((a % b) != '0);
  endfunction

  function automatic logic [WORD_W-1:0] safe_div(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    return (b == '0) ? '0 : (a / b);
  endfunction

  assign advance = busy_q && has_rem(per_q, div_q) && (div_q < per_q);
  assign finish  = busy_q && !advance;
  assign fail    = (div_q == per_q);
  assign quot    = safe_div(per_q, div_q);
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      per_q    <= '0;
      div_q    <= '0;
      step_cnt <= '0;
    end else if (load) begin
      busy_q   <= 1'b1;
      per_q    <= per_in;
      div_q    <= div_in;
      step_cnt <= '0;
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (advance) begin
      div_q    <= div_q + 1'b1;
      step_cnt <= step_cnt + 1'b1;
    end
  end

  AST_DIV_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (div_q <= per_q)); // R3
  AST_SEARCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy_q); // R11
  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step_cnt <= {1'b0, per_q})); // R11
endmodule

// File: rtl/dma_thresh_planner.sv
module dma_thresh_planner
  import dtp_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W:0]   period_bytes,
  input  logic              wide_sample,
  input  logic [WORD_W-1:0] max_thresh,
  input  logic [CH_W-1:0]   channels,
  input  logic              thresh_mode,
  output logic              done,
  output logic              err,
  output logic [1:0]        sync_mode,
  output logic [WORD_W-1:0] pkt_size,
  output logic [WORD_W-1:0] thresh_words
);
  localparam int CH_PAD = WORD_W - CH_W;
  localparam logic [WORD_W-1:0] ONE_W = WORD_W'(1);

  function automatic logic [WORD_W-1:0] ceil_div(input logic [WORD_W-1:0] p, input logic [WORD_W-1:0] m);
    return (p / m) + {{(WORD_W-1){1'b0}}, ((p % m) != '0)};
  endfunction

  logic [WORD_W-1:0] words, max_c, first_div, ch_ext;
  logic              accept, direct, load;
  logic              srch_busy, srch_finish, srch_fail;
  logic [WORD_W-1:0] srch_quot;
  sync_e             dir_mode;
  logic [WORD_W-1:0] dir_pkt, dir_thr;

  logic              done_q, err_q, req_tm;
  sync_e             mode_q;
  logic [WORD_W-1:0] pkt_q, thr_q, req_per, req_max;

  dtp_word_conv #(.WORD_W(WORD_W)) conv_i (
    .bytes_in (period_bytes),
    .wide     (wide_sample),
    .words_out(words)
  );

  assign max_c     = (max_thresh == '0) ? ONE_W : max_thresh;  // R8
  assign ch_ext    = {{CH_PAD{1'b0}}, channels};
  assign accept    = start && !srch_busy;                       // R10
  assign direct    = !thresh_mode || (words <= max_c);
  assign load      = accept && !direct;
  assign first_div = ceil_div(words, max_c);                    // R3

  always_comb begin
    if (thresh_mode) begin
      dir_mode = SYNC_FRAME;   dir_pkt = '0;     dir_thr = words;   // R2
    end else if (channels > CH_W'(1)) begin
      dir_mode = SYNC_PACKET;  dir_pkt = ch_ext; dir_thr = ch_ext;  // R6
    end else begin
      dir_mode = SYNC_ELEMENT; dir_pkt = '0;     dir_thr = ONE_W;   // R7
    end
  end

  dtp_div_search #(.WORD_W(WORD_W)) search_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .per_in(words),
    .div_in(first_div),
    .busy  (srch_busy),
    .finish(srch_finish),
    .fail  (srch_fail),
    .quot  (srch_quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      mode_q  <= SYNC_ELEMENT;
      pkt_q   <= '0;
      thr_q   <= '0;
      req_per <= '0;
      req_max <= '0;
      req_tm  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        req_per <= words;
        req_max <= max_c;
        req_tm  <= thresh_mode;
        if (direct) begin
          done_q <= 1'b1;
          err_q  <= 1'b0;
          mode_q <= dir_mode;
          pkt_q  <= dir_pkt;
          thr_q  <= dir_thr;
        end
      end else if (srch_finish) begin
        done_q <= 1'b1;
        if (srch_fail) begin
          err_q  <= 1'b1;           // R4
          mode_q <= SYNC_ELEMENT;
          pkt_q  <= '0;
          thr_q  <= '0;
        end else begin
          err_q  <= 1'b0;           // R5
          mode_q <= SYNC_PACKET;
          pkt_q  <= srch_quot;
          thr_q  <= srch_quot;
        end
      end
    end
  end

  assign done         = done_q;
  assign err          = err_q;
  assign sync_mode    = mode_q;
  assign pkt_size     = pkt_q;
  assign thresh_words = thr_q;

  AST_ERR_NO_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (mode_q == SYNC_ELEMENT && pkt_q == '0 && thr_q == '0)); // R4
  AST_PKT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !err_q && req_tm && mode_q == SYNC_PACKET) |->
      (pkt_q != '0 && pkt_q <= req_max && (req_per % pkt_q) == '0)); // R5
  AST_THR_IS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q == SYNC_PACKET) |-> (thr_q == pkt_q)); // R5
  AST_FRAME_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q == SYNC_FRAME) |-> (thr_q == req_per && thr_q <= req_max)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_busy && start) |=> ($stable(req_per) && $stable(req_max))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> !done_q); // R9
endmodule

// File: tb/dma_thresh_planner_tb.sv
module dma_thresh_planner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 12;
  localparam int CH_W   = 5;
  localparam int WATCHDOG_CYCLES = 190000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [WORD_W:0]   period_bytes = '0;
  logic              wide_sample = 1'b0;
  logic [WORD_W-1:0] max_thresh = '0;
  logic [CH_W-1:0]   channels = '0;
  logic              thresh_mode = 1'b0;
  logic              done, err;
  logic [1:0]        sync_mode;
  logic [WORD_W-1:0] pkt_size, thresh_words;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_thresh_planner #(.WORD_W(WORD_W), .CH_W(CH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .period_bytes(period_bytes),
    .wide_sample(wide_sample), .max_thresh(max_thresh), .channels(channels),
    .thresh_mode(thresh_mode), .done(done), .err(err), .sync_mode(sync_mode),
    .pkt_size(pkt_size), .thresh_words(thresh_words)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int word_count(input int bytes, input bit wide);
    return wide ? bytes / 4 : bytes / 2;
  endfunction

  // Expected plan: largest divisor of P not above M, refused when only 1 fits
  function automatic void plan(input bit tm, input int ch, input int p, input int m_raw,
                               output int mode, output int pkt, output int thr, output int e);
    int m = (m_raw == 0) ? 1 : m_raw;
    int q = 1;
    e = 0;
    if (!tm) begin
      if (ch > 1) begin mode = 2; pkt = ch; thr = ch; end
      else begin mode = 0; pkt = 0; thr = 1; end
    end else if (p <= m) begin
      mode = 1; pkt = 0; thr = p;
    end else begin
      for (int c = m; c >= 1; c--) begin
        if (p % c == 0) begin q = c; break; end
      end
      if (q == 1) begin mode = 0; pkt = 0; thr = 0; e = 1; end
      else begin mode = 2; pkt = q; thr = q; end
    end
  endfunction

  task automatic drive(input int bytes, input bit wide, input int mx, input int ch, input bit tm);
    period_bytes = (WORD_W+1)'(bytes);
    wide_sample  = wide;
    max_thresh   = WORD_W'(mx);
    channels     = CH_W'(ch);
    thresh_mode  = tm;
  endtask

  task automatic run_case(input int bytes, input bit wide, input int mx, input int ch,
                          input bit tm, input string req);
    int p, mode, pkt, thr, e, cnt, lim;
    p = word_count(bytes, wide);
    plan(tm, ch, p, mx, mode, pkt, thr, e);
    drive(bytes, wide, mx, ch, tm);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 6000) begin
      @(negedge clk);
      cnt++;
    end
    lim = (p < 1) ? 1 : p;
    chk(done == 1'b1, req, "done seen", int'(done), 1);
    chk(cnt <= lim, "R11", "latency", cnt, lim);
    if (!tm || p <= ((mx == 0) ? 1 : mx))
      chk(cnt == 1, "R9", "direct latency", cnt, 1);
    chk(int'(sync_mode) == mode, req, "sync_mode", int'(sync_mode), mode);
    chk(int'(pkt_size) == pkt, req, "pkt_size", int'(pkt_size), pkt);
    chk(int'(thresh_words) == thr, req, "thresh_words", int'(thresh_words), thr);
    chk(int'(err) == e, req, "err", int'(err), e);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done pulse width", int'(done), 0);
    chk(int'(thresh_words) == thr, "R9", "held thresh_words", int'(thresh_words), thr);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG_CYCLES, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(done == 1'b0, "R12", "done", int'(done), 0);
    chk(err == 1'b0, "R12", "err", int'(err), 0);
    chk(sync_mode == 2'd0, "R12", "sync_mode", int'(sync_mode), 0);
    chk(pkt_size == '0, "R12", "pkt_size", int'(pkt_size), 0);
    chk(thresh_words == '0, "R12", "thresh_words", int'(thresh_words), 0);

    run_case(64, 1'b0, 32, 1, 1'b1, "R2");      // P == M boundary
    run_case(66, 1'b0, 32, 1, 1'b1, "R5");      // P=33 -> 11
    run_case(62, 1'b0, 16, 1, 1'b1, "R4");      // prime 31 refused
    run_case(2, 1'b0, 0, 1, 1'b1, "R8");        // M=0 acts as 1, P=1 fits
    run_case(8, 1'b0, 0, 1, 1'b1, "R8");        // M=0, P=4 refused
    run_case(203, 1'b1, 64, 1, 1'b1, "R1");     // 50 words from 32-bit
    run_case(203, 1'b0, 200, 1, 1'b1, "R1");    // 101 words from 16-bit
    run_case(100, 1'b0, 5, 2, 1'b0, "R6");      // stereo packet
    run_case(100, 1'b0, 5, 16, 1'b0, "R6");
    run_case(100, 1'b0, 5, 1, 1'b0, "R7");      // mono element
    run_case(100, 1'b0, 5, 0, 1'b0, "R7");
    run_case(8186, 1'b0, 2, 1, 1'b1, "R3");     // prime 4093, long search
    run_case(8190, 1'b0, 4094, 1, 1'b1, "R3");  // 4095 words -> 1365

    // R10: start held through a search, including its finishing edge
    drive(600, 1'b0, 7, 1, 1'b1);               // 300 words, M=7 -> 6
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(100, 1'b0, 5, 2, 1'b0);               // competing request
    gap = 1;
    while (!done && gap < 6000) begin
      @(negedge clk);
      gap++;
    end
    start = 1'b0;
    chk(int'(sync_mode) == 2, "R10", "first request mode", int'(sync_mode), 2);
    chk(int'(pkt_size) == 6, "R10", "first request pkt", int'(pkt_size), 6);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R10", "no extra done", int'(done), 0);
    end
    chk(int'(pkt_size) == 6, "R10", "result kept", int'(pkt_size), 6);

    // Constrained random mix
    for (int n = 0; n < 200; n++) begin
      int b, mx, ch;
      bit w, tm;
      b  = int'($urandom % 1024);
      w  = 1'($urandom % 2);
      mx = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 300);
      ch = int'($urandom % 17);
      tm = ($urandom % 4) != 0;
      run_case(b, w, mx, ch, tm, tm ? "R5" : "R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule